// File: doc/BRIEF.md
# Front-Panel Trigger Crosspoint with Divided Sync Clock

This block routes trigger signals to six single-ended front-panel lines. Each line has its own 5-bit source code. The code picks one of the following: another front-panel line, one of three differential line pairs, one of eight backplane trigger lines, a star trigger, a differential star trigger, a software trigger pulse, a synchronization clock at one of three rates, or a fixed level. Every routed line also has an enable output. The enable tells the pad driver whether the line is in use.

A single synchronization clock is shared by all routes. It is taken from one of four reference clock inputs. Two power-of-two dividers run in parallel on that clock, and each has its own exponent. A route asks for the full-rate clock, the first divider's output or the second divider's output simply by its source code. The reference clocks are sampled in the `clk` domain and then passed through a two-stage level and edge stage. Because of this, every reference must be slower than half of `clk`.

Configuration is loaded through a simple write port. Writes take effect on the next clock edge. Each routed line is registered, so a newly selected source shows up at the pin one cycle after the write has landed.

Top module: `trig_xpoint`

## Requirements
- R1: During and after reset, every `trig_out` bit is 0 and every `trig_oe` bit is 0. All source codes reset to 31.
- R2: Codes 0 to 5 select the registered value of front-panel line 0 to 5. Route outputs are registered, with one cycle of latency.
- R3: Codes 6 to 8 select `diff_in[0..2]`. Codes 9 to 16 select `bp_trig[0..7]`. Code 17 selects `star_in` and code 18 selects `dstar_in`. The routed value appears one clock after the write or input change, and `trig_oe` is 1.
- R4: A line whose code equals its own index drives 0 with `trig_oe` at 1.
- R5: Code 23 drives a steady 0 and code 24 drives a steady 1. In both cases `trig_oe` is 1.
- R6: Codes 25 to 31 drive 0 with `trig_oe` at 0.
- R7: A write to address 9 raises the software trigger for exactly one cycle. Every line using code 19 shows it as a one-cycle high, two clock edges after the write edge.
- R8: Address 6 (data bits [1:0]) selects reference clock 0 to 3 as the sync clock. Code 20 routes that clock at full rate.
- R9: Address 7 sets the first divider exponent n (data 0 to 9). Code 21 routes the sync clock divided by 2^n, with a 50% duty cycle. A change of n restarts the divider from zero.
- R10: Address 8 sets the second divider exponent m in the same way, routed by code 22. The two dividers run independently of each other.
- R11: An exponent write with data above 9 is ignored, and the previous exponent stays in effect.
- R12: Addresses 0 to 5 set the source code of line 0 to 5 (data bits [4:0]). Each line follows only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| diff_in | input | 3 | Received differential pair levels |
| bp_trig | input | 8 | Backplane trigger lines |
| star_in | input | 1 | Star trigger |
| dstar_in | input | 1 | Differential star trigger |
| ref_clk | input | 4 | Candidate reference clocks for the sync clock |
| trig_out | output | 6 | Routed front-panel trigger lines |
| trig_oe | output | 6 | Per-line output enables |

## Verification
The hardest behaviour to reach from the ports is the divided clock at the largest exponents. At n = 9, a period lasts over a thousand cycles. Just after an exponent change, the first edge is only a partial period. The stimulus programs each divider exponent from 0 to 9, with the two dividers set to complementary values. It then skips the first rising edge and measures a full period and its high time between the next two edges. These are compared with 2^n reference periods and half of that. Line-to-line routing is reached by driving one line to a constant and pointing every other line at it.

// File: rtl/trigmx_pkg.sv
// Shared sizes and source-code map for the trigger crosspoint.
// Assumes source codes fit in SEL_W bits and N_SRC <= 2**SEL_W.
package trigmx_pkg;
    localparam int N_FP     = 6;
    localparam int N_DIFF   = 3;
    localparam int N_BP     = 8;
    localparam int N_REF    = 4;
    localparam int MAX_EXP  = 9;
    localparam int SEL_W    = 5;
    localparam int EXP_W    = 4;
    localparam int REF_W    = $clog2(N_REF);
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;

    localparam int CODE_FP0   = 0;
    localparam int CODE_DIFF0 = CODE_FP0 + N_FP;
    localparam int CODE_BP0   = CODE_DIFF0 + N_DIFF;
    localparam int CODE_STAR  = CODE_BP0 + N_BP;
    localparam int CODE_DSTAR = CODE_STAR + 1;
    localparam int CODE_SW    = CODE_DSTAR + 1;
    localparam int CODE_SYNC  = CODE_SW + 1;
    localparam int CODE_DIVA  = CODE_SYNC + 1;
    localparam int CODE_DIVB  = CODE_DIVA + 1;
    localparam int CODE_LOW   = CODE_DIVB + 1;
    localparam int CODE_HIGH  = CODE_LOW + 1;
    localparam int N_SRC      = CODE_HIGH + 1;
    localparam int CODE_OFF   = (1 << SEL_W) - 1;

    localparam int ADDR_SSEL  = N_FP;
    localparam int ADDR_EXPA  = N_FP + 1;
    localparam int ADDR_EXPB  = N_FP + 2;
    localparam int ADDR_SW    = N_FP + 3;
endpackage

// File: rtl/trigmx_cfg.sv
// Configuration registers: per-line source codes, sync reference select,
// two divider exponents and the software trigger pulse.
// Assumes one write per cycle; exponent writes above MAX_EXP are dropped.
module trigmx_cfg
    import trigmx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [N_FP-1:0][SEL_W-1:0]    sel,
    output logic [REF_W-1:0]              ref_sel,
    output logic [EXP_W-1:0]              exp_a,
    output logic [EXP_W-1:0]              exp_b,
    output logic                          sw_pulse
);
    logic exp_ok;
    assign exp_ok = (wdata <= DATA_W'(MAX_EXP));

    // Source-code registers, one per front-panel line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_FP; i++) sel[i] <= SEL_W'(CODE_OFF);
        end else if (we) begin
            for (int i = 0; i < N_FP; i++)
                if (addr == ADDR_W'(i)) sel[i] <= wdata[SEL_W-1:0];
        end
    end

    // Sync reference select and divider exponents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sel <= '0;
            exp_a   <= '0;
            exp_b   <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_SSEL)) ref_sel <= wdata[REF_W-1:0];
            if (addr == ADDR_W'(ADDR_EXPA) && exp_ok) exp_a <= wdata[EXP_W-1:0];
            if (addr == ADDR_W'(ADDR_EXPB) && exp_ok) exp_b <= wdata[EXP_W-1:0];
        end
    end

    // One-cycle software trigger on each write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_pulse <= 1'b0;
        else        sw_pulse <= we && (addr == ADDR_W'(ADDR_SW));
    end

    p_exp_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(ADDR_EXPA) && wdata > DATA_W'(MAX_EXP)) |=> $stable(exp_a));
    p_sw_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(ADDR_SW)) |=> sw_pulse);
    p_sw_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pulse && !(we && addr == ADDR_W'(ADDR_SW))) |=> !sw_pulse);
endmodule

// File: rtl/trigmx_syncsel.sv
// Picks one reference clock, samples it into the clk domain and flags its
// rising edges. Assumes every reference is slower than half of clk.
module trigmx_syncsel
    import trigmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REF-1:0]  ref_clk,
    input  logic [REF_W-1:0]  ref_sel,
    output logic              lvl,
    output logic              rise
);
    logic lvl_d;

    // Two-stage sample of the chosen reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl   <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            lvl   <= ref_clk[ref_sel];
            lvl_d <= lvl;
        end
    end

    assign rise = lvl && !lvl_d;
endmodule

// File: rtl/trigmx_clkdiv.sv
// Power-of-two divider of the sampled sync clock. Exponent 0 passes the
// level through; exponent n>0 outputs bit n-1 of a rise counter (50% duty).
// The counter clears whenever the exponent changes.
module trigmx_clkdiv #(
    parameter int EXP_W = 4,
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic              lvl,
    input  logic              rise,
    output logic              div_out
);
    logic [EXP_W-1:0] exp_q;
    logic [CNT_W-1:0] cnt;
    logic [EXP_W-1:0] bit_idx;

    // Count reference rising edges; restart on exponent change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            cnt   <= '0;
        end else if (exp_in != exp_q) begin
            exp_q <= exp_in;
            cnt   <= '0;
        end else if (rise) begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign bit_idx = exp_q - EXP_W'(1);
    assign div_out = (exp_q == '0) ? lvl : cnt[bit_idx];

    p_clear_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_in != exp_q) |=> (cnt == '0));
    p_hold_without_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && exp_in == exp_q) |=> $stable(cnt));
endmodule

// File: rtl/trigmx_route.sv
// One output line of the crosspoint: registers the source picked by its code.
// Self-selection drives low; codes at or above N_SRC disable the line.
module trigmx_route
    import trigmx_pkg::*;
#(
    parameter int SELF = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  code,
    input  logic [N_SRC-1:0]  src,
    output logic              out,
    output logic              oe
);
    // Register routed value and enable for this line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out <= 1'b0;
            oe  <= 1'b0;
        end else if (code >= SEL_W'(N_SRC)) begin
            out <= 1'b0;
            oe  <= 1'b0;
        end else if (code == SEL_W'(SELF)) begin
            out <= 1'b0;
            oe  <= 1'b1;
        end else begin
            out <= src[code];
            oe  <= 1'b1;
        end
    end

    p_unused_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= SEL_W'(N_SRC)) |=> (!out && !oe));
    p_self_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SEL_W'(SELF)) |=> (!out && oe));
    p_const_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SEL_W'(CODE_HIGH)) |=> (out && oe));
    p_const_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SEL_W'(CODE_LOW)) |=> (!out && oe));
endmodule

// File: rtl/trig_xpoint.sv
// Top of the front-panel trigger crosspoint. Builds the source vector from
// external triggers, routed lines, the software pulse and the sync clock in
// three rates, and instantiates one registered route per line.
module trig_xpoint
    import trigmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [N_DIFF-1:0]   diff_in,
    input  logic [N_BP-1:0]     bp_trig,
    input  logic                star_in,
    input  logic                dstar_in,
    input  logic [N_REF-1:0]    ref_clk,
    output logic [N_FP-1:0]     trig_out,
    output logic [N_FP-1:0]     trig_oe
);
    logic [N_FP-1:0][SEL_W-1:0] sel;
    logic [REF_W-1:0]           ref_sel;
    logic [EXP_W-1:0]           exp_a, exp_b;
    logic                       sw_pulse;
    logic                       sync_lvl, sync_rise;
    logic                       div_a, div_b;
    logic [N_SRC-1:0]           src;

    trigmx_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .sel(sel), .ref_sel(ref_sel), .exp_a(exp_a), .exp_b(exp_b), .sw_pulse(sw_pulse)
    );

    trigmx_syncsel u_sync (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_sel(ref_sel),
        .lvl(sync_lvl), .rise(sync_rise)
    );

    trigmx_clkdiv #(.EXP_W(EXP_W), .CNT_W(MAX_EXP)) u_div_a (
        .clk(clk), .rst_n(rst_n), .exp_in(exp_a), .lvl(sync_lvl), .rise(sync_rise),
        .div_out(div_a)
    );

    trigmx_clkdiv #(.EXP_W(EXP_W), .CNT_W(MAX_EXP)) u_div_b (
        .clk(clk), .rst_n(rst_n), .exp_in(exp_b), .lvl(sync_lvl), .rise(sync_rise),
        .div_out(div_b)
    );

    // Source vector laid out in code order.
    always_comb begin
        src = '0;
        src[CODE_FP0 +: N_FP]     = trig_out;
        src[CODE_DIFF0 +: N_DIFF] = diff_in;
        src[CODE_BP0 +: N_BP]     = bp_trig;
        src[CODE_STAR]            = star_in;
        src[CODE_DSTAR]           = dstar_in;
        src[CODE_SW]              = sw_pulse;
        src[CODE_SYNC]            = sync_lvl;
        src[CODE_DIVA]            = div_a;
        src[CODE_DIVB]            = div_b;
        src[CODE_LOW]             = 1'b0;
        src[CODE_HIGH]            = 1'b1;
    end

    for (genvar g = 0; g < N_FP; g++) begin : g_route
        trigmx_route #(.SELF(g)) u_route (
            .clk(clk), .rst_n(rst_n), .code(sel[g]), .src(src),
            .out(trig_out[g]), .oe(trig_oe[g])
        );
    end
endmodule

// File: tb/tb_trig_xpoint.sv
module tb_trig_xpoint;
    localparam int C_DIFF0 = 6, C_BP0 = 9, C_STAR = 17, C_DSTAR = 18, C_SW = 19;
    localparam int C_SYNC = 20, C_DIVA = 21, C_DIVB = 22, C_LOW = 23, C_HIGH = 24;
    localparam int A_SSEL = 6, A_EXPA = 7, A_EXPB = 8, A_SW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [12:0] ext = '0;
    logic [2:0] diff_in;
    logic [7:0] bp_trig;
    logic star_in, dstar_in;
    logic [3:0] ref_clk = '0;
    logic [5:0] trig_out, trig_oe;
    int checks = 0, errors = 0, cyc = 0;
    int refcnt [4] = '{0, 0, 0, 0};

    assign {dstar_in, star_in, bp_trig, diff_in} = ext;

    always #2 clk = ~clk;

    trig_xpoint dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .diff_in(diff_in), .bp_trig(bp_trig),
        .star_in(star_in), .dstar_in(dstar_in), .ref_clk(ref_clk),
        .trig_out(trig_out), .trig_oe(trig_oe)
    );

    // Reference k toggles every k+1 cycles: period 2(k+1) clk cycles.
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (refcnt[k] == k) begin
                refcnt[k] <= 0;
                ref_clk[k] <= ~ref_clk[k];
            end else begin
                refcnt[k] <= refcnt[k] + 1;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            summary();
        end
    end

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic meas(int o, output int per, output int hi);
        int c = 0, rises = 0, t0 = 0, hc = 0;
        logic prev;
        per = -1;
        @(negedge clk);
        prev = trig_out[o];
        while (rises < 3 && c < 20000) begin
            @(negedge clk);
            c++;
            if (trig_out[o] && !prev) begin
                rises++;
                if (rises == 2) t0 = c;
                if (rises == 3) per = c - t0;
            end
            if (rises == 2 && trig_out[o]) hc++;
            prev = trig_out[o];
        end
        hi = hc;
    endtask

    initial begin
        int per, hi, per2, hi2;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 out after reset asserted", trig_out, 0);
        chk("R1 oe during reset", trig_oe, 0);
        rst_n = 1'b1;
        settle();
        chk("R1 out after reset", trig_out, 0);
        chk("R1 oe after reset", trig_oe, 0);

        // R3: every external source on every line, both polarities.
        for (int o = 0; o < 6; o++) begin
            for (int c = C_DIFF0; c <= C_DSTAR; c++) begin
                ext = '0;
                ext[c - C_DIFF0] = 1'b1;
                wr(o, c);
                settle();
                chk($sformatf("R3 line %0d code %0d high", o, c), trig_out[o], 1);
                chk("R3 oe", trig_oe[o], 1);
                ext = '1;
                ext[c - C_DIFF0] = 1'b0;
                settle();
                chk($sformatf("R3 line %0d code %0d low", o, c), trig_out[o], 0);
            end
            wr(o, 31);
        end
        ext = '0;

        // R2: line-to-line routing for every ordered pair.
        for (int s = 0; s < 6; s++) begin
            for (int d = 0; d < 6; d++) begin
                if (d != s) begin
                    wr(s, C_HIGH);
                    wr(d, s);
                    settle();
                    chk($sformatf("R2 line %0d from %0d high", d, s), trig_out[d], 1);
                    wr(s, C_LOW);
                    settle();
                    chk($sformatf("R2 line %0d from %0d low", d, s), trig_out[d], 0);
                    chk("R5 const low oe", trig_oe[s], 1);
                    wr(d, 31);
                    wr(s, 31);
                end
            end
        end

        // R4 self select, R6 unused codes.
        for (int o = 0; o < 6; o++) begin
            wr(o, o);
            settle();
            chk($sformatf("R4 self line %0d out", o), trig_out[o], 0);
            chk($sformatf("R4 self line %0d oe", o), trig_oe[o], 1);
            for (int c = 25; c < 32; c++) begin
                wr(o, C_HIGH);
                settle();
                chk("R5 const high", trig_out[o], 1);
                wr(o, c);
                settle();
                chk($sformatf("R6 code %0d out", c), trig_out[o], 0);
                chk($sformatf("R6 code %0d oe", c), trig_oe[o], 0);
            end
        end

        // R12: all lines with different codes at once.
        ext = '0;
        ext[0] = 1'b1;
        wr(0, C_HIGH); wr(1, C_LOW); wr(2, C_DIFF0); wr(3, 31); wr(4, 3); wr(5, C_BP0);
        settle();
        chk("R12 mixed outputs", trig_out, 6'b000101);
        chk("R12 mixed enables", trig_oe, 6'b110111);
        ext = '0;

        // R7: software trigger pulse timing.
        wr(2, C_SW);
        wr(4, C_SW);
        settle();
        wr(A_SW, 0);
        chk("R7 before pulse", trig_out[2], 0);
        @(posedge clk); @(negedge clk);
        chk("R7 pulse line 2", trig_out[2], 1);
        chk("R7 pulse line 4", trig_out[4], 1);
        @(posedge clk); @(negedge clk);
        chk("R7 pulse ends", trig_out[2], 0);

        // R8: reference select, full rate and divide by 2.
        wr(A_EXPA, 1);
        wr(2, C_SYNC);
        wr(3, C_DIVA);
        for (int k = 0; k < 4; k++) begin
            wr(A_SSEL, k);
            meas(2, per, hi);
            chk($sformatf("R8 ref %0d full period", k), per, 2 * (k + 1));
            chk($sformatf("R8 ref %0d full high", k), hi, k + 1);
            meas(3, per, hi);
            chk($sformatf("R8 ref %0d div2 period", k), per, 4 * (k + 1));
        end

        // R9/R10: exponent sweep, dividers set to complementary values.
        wr(A_SSEL, 0);
        wr(0, C_DIVA);
        wr(1, C_DIVB);
        for (int n = 0; n <= 9; n++) begin
            wr(A_EXPA, n);
            wr(A_EXPB, 9 - n);
            meas(0, per, hi);
            meas(1, per2, hi2);
            chk($sformatf("R9 exp %0d period", n), per, 2 * (1 << n));
            chk($sformatf("R9 exp %0d high", n), hi, 1 << n);
            chk($sformatf("R10 exp %0d period", 9 - n), per2, 2 * (1 << (9 - n)));
            chk($sformatf("R10 exp %0d high", 9 - n), hi2, 1 << (9 - n));
        end

        // R11: illegal exponents ignored.
        wr(A_EXPA, 3);
        wr(A_EXPA, 12);
        wr(A_EXPB, 2);
        wr(A_EXPB, 10);
        meas(0, per, hi);
        chk("R11 exp A kept", per, 16);
        meas(1, per, hi);
        chk("R11 exp B kept", per, 8);

        summary();
    end
endmodule